// File: doc/BRIEF.md
# TDD Transmit/Receive Mode Sequencer

This controller reconfigures a shared amplifier core that acts as the power amplifier while transmitting and as the low-noise amplifier while receiving. A single request level selects the wanted mode. From that level the sequencer drives every control of the core: the centre-tap supply switch, the receive supply switch, the ground switch on the two top amplifier cells, the gate pull-up and gate bias switches, a per-cell cascode grounding vector, the side-branch and adjacent-branch forcing vectors, and a flag that holds the input drivers at a constant level.

Each mode change is break-before-make. The switches of the old mode all open together. The core then sits in a neutral gap, with every switch open and the drivers held, for a programmable number of cycles. Only after that gap does the configuration of the new mode appear. A request that changes during a sequence never disturbs the sequence in progress; it is taken up once that sequence completes. All outputs come from flops, so no decode glitch reaches the analog switches.

Top module: `tdd_mode_seq`

## Requirements
- R1: In steady transmit (`mode_rx`=0, `busy`=0), `ctap_sup_en`, `pa_gnd_en` and `gate_pu_en` are 1; `lna_sup_en`, `gate_bias_en` and `drv_hold` are 0; `casc_gnd`, `side_on` and `adj_off` are all zero.
- R2: In steady receive (`mode_rx`=1, `busy`=0), `lna_sup_en`, `gate_bias_en` and `drv_hold` are 1; `ctap_sup_en`, `pa_gnd_en` and `gate_pu_en` are 0; `casc_gnd` equals parameter `RX_CASC_GND` (bit i set drives cascode i to ground, default 4'b0101); `side_on` and `adj_off` are all ones.
- R3: During a gap (`busy`=1), all five switch enables are 0, `drv_hold` is 1, `casc_gnd`, `side_on` and `adj_off` are zero, and `mode_rx` is 0.
- R4: A request level that differs from the current steady mode, sampled at a clock edge, gives the gap from that edge. The gap lasts D edges, where D is `dead_cycles` (a value of 0 counts as 1). The new mode appears after edge D+1.
- R5: No transmit-side enable (`ctap_sup_en`, `pa_gnd_en`, `gate_pu_en`) is ever 1 in the same cycle as a receive-side enable (`lna_sup_en`, `gate_bias_en`, any `side_on` bit). In particular, `gate_pu_en` and `gate_bias_en` are never 1 together.
- R6: No cycle with a transmit-side enable active is directly followed by a cycle with a receive-side enable active, and the same holds in the opposite direction.
- R7: A change of `mode_req` during a gap does not alter the sequence in progress. That sequence still ends in its target mode, which shows for one cycle with `busy`=0. The next sequence then starts if the request differs.
- R8: While `rst_n` is 0, the outputs hold the gap configuration with `busy`=1. After release, the gap lasts D edges and the block then enters transmit, whatever `mode_req` is.
- R9: While `mode_req` matches the steady mode, the outputs stay constant and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 1 | Requested mode: 0 transmit, 1 receive |
| dead_cycles | input | DEAD_W | Gap length in cycles; 0 is treated as 1 |
| ctap_sup_en | output | 1 | Centre-tap amplifier supply switch |
| lna_sup_en | output | 1 | Receive amplifier supply switch |
| pa_gnd_en | output | 1 | Ground switch of the two top amplifier cells |
| gate_pu_en | output | 1 | Gate pull-up to cascode level |
| gate_bias_en | output | 1 | Resistive gate bias switch |
| drv_hold | output | 1 | Input drivers held at a constant level |
| casc_gnd | output | NCASC | Per-cell cascode driven to ground |
| side_on | output | NSIDE | Side branches forced on |
| adj_off | output | NADJ | Branches next to the receive cells forced off |
| mode_rx | output | 1 | Current steady mode is receive |
| busy | output | 1 | Transition gap in progress |

## Verification
Every output is registered and decoded from the next state, so a request applied before an edge is visible in the outputs right after that edge. The gap then holds for D samples, and the new mode is due after edge D+1. The bench drives inputs on the falling edge and samples on the falling edge after the counted number of rising edges. Each table row and directed step therefore states the exact edge count at which its expected value applies. A monitor checks the exclusion and break-before-make rules on every sampled cycle.

// File: rtl/tdd_seq_pkg.sv
// Shared types for the TDD mode sequencer: state encoding and switch set.
package tdd_seq_pkg;

    typedef enum logic [1:0] {
        ST_TX  = 2'd0,
        ST_RX  = 2'd1,
        ST_GAP = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic ctap_sup;
        logic lna_sup;
        logic pa_gnd;
        logic gate_pu;
        logic gate_bias;
        logic drv_hold;
    } sw_cfg_t;

    localparam sw_cfg_t SW_GAP = '{ctap_sup: 1'b0, lna_sup: 1'b0, pa_gnd: 1'b0,
                                   gate_pu: 1'b0, gate_bias: 1'b0, drv_hold: 1'b1};

endpackage

// File: rtl/tdd_seq_fsm.sv
// Mode state machine with dead-time counter.
// Holds the steady mode, or a gap with its target and elapsed count.
// Assumes dead_cycles is stable while a gap runs; a value of 0 acts as 1.
module tdd_seq_fsm
    import tdd_seq_pkg::*;
#(
    parameter int DEAD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req,
    input  logic [DEAD_W-1:0] dead_cycles,
    output seq_state_e        st_nxt
);
    localparam logic [DEAD_W-1:0] CNT_ONE = 1;
    localparam logic [DEAD_W:0]   EXT_ONE = 1;

    seq_state_e        st;
    logic              tgt, tgt_nxt;
    logic [DEAD_W-1:0] cnt, cnt_nxt, eff_dead;
    logic              gap_done;

    // Next-state, target and counter decision.
    always_comb begin
        eff_dead = (dead_cycles == '0) ? CNT_ONE : dead_cycles;
        gap_done = ({1'b0, cnt} + EXT_ONE) >= {1'b0, eff_dead};
        st_nxt   = st;
        tgt_nxt  = tgt;
        cnt_nxt  = cnt;
        case (st)
            ST_TX: if (mode_req) begin
                st_nxt  = ST_GAP;
                tgt_nxt = 1'b1;
                cnt_nxt = '0;
            end
            ST_RX: if (!mode_req) begin
                st_nxt  = ST_GAP;
                tgt_nxt = 1'b0;
                cnt_nxt = '0;
            end
            default: begin
                if (gap_done) st_nxt = tgt ? ST_RX : ST_TX;
                else          cnt_nxt = cnt + CNT_ONE;
            end
        endcase
    end

    // State registers; reset parks in a gap aimed at transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_GAP;
            tgt <= 1'b0;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            tgt <= tgt_nxt;
            cnt <= cnt_nxt;
        end
    end

endmodule

// File: rtl/tdd_seq_decode.sv
// Maps a sequencer state to the full set of core controls.
// Purely combinational; the caller registers the result.
module tdd_seq_decode
    import tdd_seq_pkg::*;
#(
    parameter int               NCASC       = 4,
    parameter int               NSIDE       = 2,
    parameter int               NADJ        = 2,
    parameter logic [NCASC-1:0] RX_CASC_GND = 4'b0101
) (
    input  seq_state_e       st,
    output sw_cfg_t          sw,
    output logic [NCASC-1:0] casc_gnd,
    output logic [NSIDE-1:0] side_on,
    output logic [NADJ-1:0]  adj_off,
    output logic             busy,
    output logic             mode_rx
);
    logic is_rx, is_tx;

    // State flags and switch set per mode.
    always_comb begin
        is_rx   = (st == ST_RX);
        is_tx   = (st == ST_TX);
        busy    = !is_rx && !is_tx;
        mode_rx = is_rx;
        sw      = SW_GAP;
        if (is_tx) begin
            sw.ctap_sup = 1'b1;
            sw.pa_gnd   = 1'b1;
            sw.gate_pu  = 1'b1;
            sw.drv_hold = 1'b0;
        end else if (is_rx) begin
            sw.lna_sup   = 1'b1;
            sw.gate_bias = 1'b1;
        end
        side_on = {NSIDE{is_rx}};
        adj_off = {NADJ{is_rx}};
    end

    // Per-cell cascode role in receive mode.
    for (genvar i = 0; i < NCASC; i++) begin : g_casc
        assign casc_gnd[i] = is_rx && RX_CASC_GND[i];
    end

endmodule

// File: rtl/tdd_mode_seq.sv
// Break-before-make TX/RX sequencer for a shared PA/LNA core.
// Registers all controls from the next state so switches see clean levels.
// Assumes a synchronous active-low reset held for at least one edge.
module tdd_mode_seq
    import tdd_seq_pkg::*;
#(
    parameter int               DEAD_W      = 4,
    parameter int               NCASC       = 4,
    parameter int               NSIDE       = 2,
    parameter int               NADJ        = 2,
    parameter logic [NCASC-1:0] RX_CASC_GND = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req,
    input  logic [DEAD_W-1:0] dead_cycles,
    output logic              ctap_sup_en,
    output logic              lna_sup_en,
    output logic              pa_gnd_en,
    output logic              gate_pu_en,
    output logic              gate_bias_en,
    output logic              drv_hold,
    output logic [NCASC-1:0]  casc_gnd,
    output logic [NSIDE-1:0]  side_on,
    output logic [NADJ-1:0]   adj_off,
    output logic              mode_rx,
    output logic              busy
);
    seq_state_e       st_nxt;
    sw_cfg_t          sw_d, sw_q;
    logic [NCASC-1:0] casc_d, casc_q;
    logic [NSIDE-1:0] side_d, side_q;
    logic [NADJ-1:0]  adj_d, adj_q;
    logic             busy_d, busy_q, rx_d, rx_q;

    tdd_seq_fsm #(.DEAD_W(DEAD_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_req    (mode_req),
        .dead_cycles (dead_cycles),
        .st_nxt      (st_nxt)
    );

    tdd_seq_decode #(
        .NCASC(NCASC), .NSIDE(NSIDE), .NADJ(NADJ), .RX_CASC_GND(RX_CASC_GND)
    ) u_dec (
        .st       (st_nxt),
        .sw       (sw_d),
        .casc_gnd (casc_d),
        .side_on  (side_d),
        .adj_off  (adj_d),
        .busy     (busy_d),
        .mode_rx  (rx_d)
    );

    // Output registers; reset loads the gap configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q   <= SW_GAP;
            casc_q <= '0;
            side_q <= '0;
            adj_q  <= '0;
            busy_q <= 1'b1;
            rx_q   <= 1'b0;
        end else begin
            sw_q   <= sw_d;
            casc_q <= casc_d;
            side_q <= side_d;
            adj_q  <= adj_d;
            busy_q <= busy_d;
            rx_q   <= rx_d;
        end
    end

    assign ctap_sup_en  = sw_q.ctap_sup;
    assign lna_sup_en   = sw_q.lna_sup;
    assign pa_gnd_en    = sw_q.pa_gnd;
    assign gate_pu_en   = sw_q.gate_pu;
    assign gate_bias_en = sw_q.gate_bias;
    assign drv_hold     = sw_q.drv_hold;
    assign casc_gnd     = casc_q;
    assign side_on      = side_q;
    assign adj_off      = adj_q;
    assign busy         = busy_q;
    assign mode_rx      = rx_q;

endmodule

// File: rtl/tdd_mode_seq_chk.sv
// Property checker for the mode sequencer, bound to every instance.
// Observes ports only; all properties are disabled during reset.
module tdd_mode_seq_chk #(
    parameter int NSIDE = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_req,
    input logic             ctap_sup_en,
    input logic             lna_sup_en,
    input logic             pa_gnd_en,
    input logic             gate_pu_en,
    input logic             gate_bias_en,
    input logic             drv_hold,
    input logic [NSIDE-1:0] side_on,
    input logic             mode_rx,
    input logic             busy
);
    logic tx_any, rx_any;

    // Group enables by the mode they belong to.
    always_comb begin
        tx_any = ctap_sup_en || pa_gnd_en || gate_pu_en;
        rx_any = lna_sup_en || gate_bias_en || (|side_on);
    end

    AST_SUP_GND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_any && rx_any)); // R5
    AST_GATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_pu_en && gate_bias_en)); // R5
    AST_BBM_TX_RX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_any |=> !rx_any); // R6
    AST_BBM_RX_TX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_any |=> !tx_any); // R6
    AST_GAP_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!tx_any && !rx_any && drv_hold && !mode_rx)); // R3
    AST_TX_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !mode_rx) |-> (ctap_sup_en && pa_gnd_en && gate_pu_en && !drv_hold)); // R1
    AST_RX_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode_rx) |-> (lna_sup_en && gate_bias_en && drv_hold && !ctap_sup_en)); // R2
    AST_STEADY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (mode_req == mode_rx)) |=> (!busy && $stable(mode_rx))); // R9

endmodule

bind tdd_mode_seq tdd_mode_seq_chk #(.NSIDE(NSIDE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_req     (mode_req),
    .ctap_sup_en  (ctap_sup_en),
    .lna_sup_en   (lna_sup_en),
    .pa_gnd_en    (pa_gnd_en),
    .gate_pu_en   (gate_pu_en),
    .gate_bias_en (gate_bias_en),
    .drv_hold     (drv_hold),
    .side_on      (side_on),
    .mode_rx      (mode_rx),
    .busy         (busy)
);

// File: tb/tdd_mode_seq_tb.sv
`timescale 1ns/1ps
module tdd_mode_seq_tb;
    localparam logic [5:0] P_TX  = 6'b101100;
    localparam logic [5:0] P_RX  = 6'b010011;
    localparam logic [5:0] P_GAP = 6'b000001;
    localparam logic [3:0] MASK  = 4'b0101;

    // {req, dead[3:0], steps[3:0], busy, rx, pattern[5:0]}
    localparam logic [16:0] VEC [0:9] = '{
        {1'b1, 4'd2, 4'd1, 1'b1, 1'b0, P_GAP},
        {1'b1, 4'd2, 4'd1, 1'b1, 1'b0, P_GAP},
        {1'b1, 4'd2, 4'd1, 1'b0, 1'b1, P_RX},
        {1'b1, 4'd2, 4'd3, 1'b0, 1'b1, P_RX},
        {1'b0, 4'd1, 4'd1, 1'b1, 1'b0, P_GAP},
        {1'b0, 4'd1, 4'd1, 1'b0, 1'b0, P_TX},
        {1'b1, 4'd0, 4'd1, 1'b1, 1'b0, P_GAP},
        {1'b1, 4'd0, 4'd1, 1'b0, 1'b1, P_RX},
        {1'b0, 4'd5, 4'd5, 1'b1, 1'b0, P_GAP},
        {1'b0, 4'd5, 4'd1, 1'b0, 1'b0, P_TX}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_req = 1'b0;
    logic [3:0] dead_cycles = 4'd3;
    logic       ctap_sup_en, lna_sup_en, pa_gnd_en, gate_pu_en, gate_bias_en, drv_hold;
    logic [3:0] casc_gnd;
    logic [1:0] side_on, adj_off;
    logic       mode_rx, busy;
    int         n_chk = 0;
    int         n_fail = 0;
    logic       mon_en = 1'b0;
    logic       prev_tx = 1'b0, prev_rx = 1'b0;

    always #2.5 clk = ~clk;

    tdd_mode_seq u_dut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .dead_cycles(dead_cycles),
        .ctap_sup_en(ctap_sup_en), .lna_sup_en(lna_sup_en), .pa_gnd_en(pa_gnd_en),
        .gate_pu_en(gate_pu_en), .gate_bias_en(gate_bias_en), .drv_hold(drv_hold),
        .casc_gnd(casc_gnd), .side_on(side_on), .adj_off(adj_off),
        .mode_rx(mode_rx), .busy(busy)
    );

    function automatic logic [5:0] pat();
        return {ctap_sup_en, lna_sup_en, pa_gnd_en, gate_pu_en, gate_bias_en, drv_hold};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk_state(input string tag, input logic b, input logic r, input logic [5:0] p);
        chk(tag, {29'd0, b, r, 1'b0}, {29'd0, busy, mode_rx, 1'b0});
        chk(tag, {26'd0, pat()}, {26'd0, p});
    endtask

    // Every-cycle monitor for exclusion (R5) and break-before-make (R6).
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            logic tx_now, rx_now;
            tx_now = ctap_sup_en | pa_gnd_en | gate_pu_en;
            rx_now = lna_sup_en | gate_bias_en | (|side_on);
            chk("R5 exclusive enables", {31'd0, tx_now & rx_now}, 32'd0);
            chk("R6 no direct mode step", {30'd0, prev_tx & rx_now, prev_rx & tx_now}, 32'd0);
            prev_tx = tx_now;
            prev_rx = rx_now;
        end
    end

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        chk_state("R8 reset gap", 1'b1, 1'b0, P_GAP);
        chk("R8 reset vectors", {24'd0, casc_gnd, side_on, adj_off}, 32'd0);
        mode_req = 1'b1;
        rst_n = 1'b1;
        mon_en = 1'b1;
        step(2);
        chk_state("R8 gap after release", 1'b1, 1'b0, P_GAP);
        step(1);
        chk_state("R8 enters transmit", 1'b0, 1'b0, P_TX);
        mode_req = 1'b0;
        step(1);
        chk_state("R9 transmit kept", 1'b0, 1'b0, P_TX);

        // Table walk over R4 timing with several dead times.
        for (int v = 0; v < 10; v++) begin
            mode_req    = VEC[v][16];
            dead_cycles = VEC[v][15:12];
            step(int'(VEC[v][11:8]));
            chk_state($sformatf("R4 vector %0d", v), VEC[v][7], VEC[v][6], VEC[v][5:0]);
        end

        // R1 full transmit configuration.
        chk("R1 tx vectors", {24'd0, casc_gnd, side_on, adj_off}, 32'd0);

        // R2 full receive configuration.
        dead_cycles = 4'd1;
        mode_req = 1'b1;
        step(2);
        chk_state("R2 rx switches", 1'b0, 1'b1, P_RX);
        chk("R2 rx vectors", {24'd0, casc_gnd, side_on, adj_off}, {24'd0, MASK, 2'b11, 2'b11});

        // R3 gap contents on the way back.
        mode_req = 1'b0;
        step(1);
        chk_state("R3 gap switches", 1'b1, 1'b0, P_GAP);
        chk("R3 gap vectors", {24'd0, casc_gnd, side_on, adj_off}, 32'd0);
        step(1);
        chk_state("R4 back in tx", 1'b0, 1'b0, P_TX);

        // R9 long hold.
        step(20);
        chk_state("R9 tx after hold", 1'b0, 1'b0, P_TX);

        // R7 request reverts during the gap.
        dead_cycles = 4'd3;
        mode_req = 1'b1;
        step(1);
        chk_state("R7 gap starts", 1'b1, 1'b0, P_GAP);
        mode_req = 1'b0;
        step(2);
        chk_state("R7 gap unchanged", 1'b1, 1'b0, P_GAP);
        step(1);
        chk_state("R7 target reached", 1'b0, 1'b1, P_RX);
        step(1);
        chk_state("R7 new sequence", 1'b1, 1'b0, P_GAP);
        step(3);
        chk_state("R7 back to tx", 1'b0, 1'b0, P_TX);

        // R8 reset in receive, then transmit despite a receive request.
        dead_cycles = 4'd1;
        mode_req = 1'b1;
        step(2);
        chk_state("R8 pre-reset rx", 1'b0, 1'b1, P_RX);
        rst_n = 1'b0;
        mon_en = 1'b0;
        step(1);
        chk_state("R8 reset from rx", 1'b1, 1'b0, P_GAP);
        rst_n = 1'b1;
        step(1);
        chk_state("R8 tx after reset", 1'b0, 1'b0, P_TX);
        step(1);
        chk_state("R4 rx request after reset", 1'b1, 1'b0, P_GAP);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule